// File: doc/BRIEF.md
# Command Ring Pointer Manager

This block keeps the bookkeeping for a circular command buffer that lives in external memory and is shared between a producer, which writes command bursts, and a graphics command processor, which consumes them. It holds eight 32-bit registers: ring start, ring limit, write pointer, read pointer, fill distance, breakpoint address, and an upper and a lower fill threshold. Software reaches each register through a 16-bit port as two halves. Each half-write leaves the other half of the register unchanged.

Each accepted producer burst moves the write pointer on by one burst and adds one burst to the fill distance. Each accepted consumer step moves the read pointer on and takes one burst from the distance. Both pointers go back to the ring start when they are already at or past the ring limit. All eight registers are exported as plain buses to a neighbouring status and interrupt unit.

Top module: `cmd_ring_ptr_mgr`

## Requirements
- R1: After a synchronous active-low reset, all eight registers read as zero, `consume_ack` is low and `reg_rvalid` is low.
- R2: Register `k` (0 start, 1 limit, 2 write pointer, 3 read pointer, 4 distance, 5 breakpoint, 6 upper threshold, 7 lower threshold) is at `reg_addr = 2k` for bits 15:0 and at `2k+1` for bits 31:16. A write to one half leaves the other half unchanged.
- R3: A low-half write to registers 0 to 5 clears bits 4:0 of the written value, so these registers stay 32-byte aligned.
- R4: A low-half write to registers 6 and 7 stores all 16 bits unchanged.
- R5: While `link_en` is low, `burst_valid` changes neither the write pointer nor the distance.
- R6: On an accepted burst (`burst_valid` and `link_en`), the write pointer is reloaded from the ring start if it is greater than or equal to the ring limit. Otherwise it grows by 32.
- R7: An accepted burst without an accepted consumer step adds 32 to the distance.
- R8: `consume_ack` is high only when `consume_req` and `read_en` are both high and the distance is nonzero. Without it, the read pointer and the distance do not change.
- R9: An accepted consumer step moves the read pointer by the same rule as R6 and takes 32 from the distance. An accepted burst and an accepted step in the same cycle leave the distance unchanged.
- R10: Addresses 16 to 31 are unmapped. Reads from them return zero, and writes to them change no register.
- R11: When a register write and a pointer or distance update from R6, R7 or R9 hit the same register in one cycle, the register write wins for that register. Other registers still take their own updates.
- R12: A read request returns its data on `reg_rdata` in the next cycle, with `reg_rvalid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Half-register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| link_en | input | 1 | Producer link enable |
| read_en | input | 1 | Consumer read enable |
| burst_valid | input | 1 | Producer burst event |
| consume_req | input | 1 | Consumer step request |
| consume_ack | output | 1 | Consumer step accepted |
| base_o | output | 32 | Ring start |
| end_o | output | 32 | Ring limit |
| wr_ptr_o | output | 32 | Write pointer |
| rd_ptr_o | output | 32 | Read pointer |
| dist_o | output | 32 | Fill distance |
| brk_o | output | 32 | Breakpoint address |
| hi_wm_o | output | 32 | Upper fill threshold |
| lo_wm_o | output | 32 | Lower fill threshold |

## Verification
The hardest cases to reach from the ports are the cycles where two writers meet: a burst and a consumer step in the same cycle, and a register write landing on a pointer in the same cycle as a burst. To reach them, the stimulus first builds a ring of a few bursts through half-writes. It places the write pointer exactly on the ring limit so that the next burst wraps. It then puts the read pointer one step below the limit and drains the ring. Along the way it issues a combined burst and consumer step, and then a burst in the same cycle as a write-pointer half-write. Finally it requests a consumer step with the distance at zero, which must be refused.

// File: rtl/cmd_ring_pkg.sv
// Package: shared index type and geometry for the command ring pointer manager.
// Assumes the register port addresses 16-bit halves of 32-bit registers.
package cmd_ring_pkg;
    localparam int unsigned RING_REGS = 8;
    localparam int unsigned RING_IDX_W = $clog2(RING_REGS);

    typedef enum logic [RING_IDX_W-1:0] {
        RG_START = 3'd0,
        RG_LIMIT = 3'd1,
        RG_WPTR  = 3'd2,
        RG_RPTR  = 3'd3,
        RG_DIST  = 3'd4,
        RG_BRK   = 3'd5,
        RG_HIWM  = 3'd6,
        RG_LOWM  = 3'd7
    } ring_reg_e;

    // Registers below this index get their low half aligned on write.
    localparam int unsigned ALIGNED_REGS = 6;
endpackage

// File: rtl/cmd_ring_half_reg.sv
// Module: one 32-bit register written as two 16-bit halves, plus a
// full-width hardware load. A software half-write wins over the hardware load.
// Assumes wr_lo and wr_hi are never high together.
module cmd_ring_half_reg #(
    parameter int HALF_W      = 16,
    parameter int BURST_BYTES = 32,
    parameter bit ALIGN_LO    = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                hw_load,
    input  logic [2*HALF_W-1:0] hw_val,
    output logic [2*HALF_W-1:0] q
);
    localparam logic [HALF_W-1:0] OFFS_BITS = HALF_W'(BURST_BYTES - 1);
    localparam logic [HALF_W-1:0] LO_MASK   = ALIGN_LO ? ~OFFS_BITS : '1;

    // Register update: reset, half-writes first, then hardware load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_lo) begin
            q[HALF_W-1:0] <= wdata & LO_MASK;
        end else if (wr_hi) begin
            q[2*HALF_W-1:HALF_W] <= wdata;
        end else if (hw_load) begin
            q <= hw_val;
        end
    end
endmodule

// File: rtl/cmd_ring_step.sv
// Module: next position of a ring pointer. It reloads the start when the
// pointer is at or past the limit, and otherwise adds one burst.
// Pure combinational logic.
module cmd_ring_step #(
    parameter int PTR_W       = 32,
    parameter int BURST_BYTES = 32
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] start,
    input  logic [PTR_W-1:0] limit,
    output logic [PTR_W-1:0] nxt
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(BURST_BYTES);

    // Wrap-or-advance selection.
    always_comb begin
        nxt = (cur >= limit) ? start : cur + STEP;
    end
endmodule

// File: rtl/cmd_ring_regs.sv
// Module: bank of eight half-writable ring registers, with write decode and a
// registered read mux. Unmapped addresses read zero and write nothing.
// Assumes hw_load/hw_val come from the pointer logic in the parent.
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int BURST_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [HALF_W-1:0]   reg_rdata,
    output logic                reg_rvalid,
    input  logic [RING_REGS-1:0] hw_load,
    input  logic [2*HALF_W-1:0] hw_val [RING_REGS],
    output logic [2*HALF_W-1:0] q      [RING_REGS]
);
    localparam int PTR_W = 2 * HALF_W;

    logic                  mapped;
    logic [RING_IDX_W-1:0] idx;
    logic                  hi_half;
    logic [RING_REGS-1:0]  wr_lo;
    logic [RING_REGS-1:0]  wr_hi;

    // Address split: half select, register index, unmapped upper bits.
    always_comb begin
        hi_half = reg_addr[0];
        idx     = reg_addr[RING_IDX_W:1];
        mapped  = (reg_addr[ADDR_W-1:RING_IDX_W+1] == '0);
    end

    // Per-register half-write strobes.
    always_comb begin
        for (int i = 0; i < RING_REGS; i++) begin
            wr_lo[i] = reg_en && reg_we && mapped && !hi_half && (idx == RING_IDX_W'(i));
            wr_hi[i] = reg_en && reg_we && mapped &&  hi_half && (idx == RING_IDX_W'(i));
        end
    end

    for (genvar g = 0; g < RING_REGS; g++) begin : g_reg
        cmd_ring_half_reg #(
            .HALF_W     (HALF_W),
            .BURST_BYTES(BURST_BYTES),
            .ALIGN_LO   (g < ALIGNED_REGS)
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (wr_lo[g]),
            .wr_hi  (wr_hi[g]),
            .wdata  (reg_wdata),
            .hw_load(hw_load[g]),
            .hw_val (hw_val[g]),
            .q      (q[g])
        );
    end

    // Registered read path, with a one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_en && !reg_we;
            if (reg_en && !reg_we) begin
                if (!mapped)      reg_rdata <= '0;
                else if (hi_half) reg_rdata <= q[idx][PTR_W-1:HALF_W];
                else              reg_rdata <= q[idx][HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cmd_ring_ptr_mgr.sv
// Module: top of the command ring pointer manager. It accepts producer bursts
// and consumer steps, moves the write and read pointers around the ring, and
// keeps the fill distance. Assumes one burst or step is 32 bytes by default
// and that the start and limit registers hold aligned addresses.
module cmd_ring_ptr_mgr
    import cmd_ring_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int BURST_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [HALF_W-1:0]   reg_rdata,
    output logic                reg_rvalid,
    input  logic                link_en,
    input  logic                read_en,
    input  logic                burst_valid,
    input  logic                consume_req,
    output logic                consume_ack,
    output logic [2*HALF_W-1:0] base_o,
    output logic [2*HALF_W-1:0] end_o,
    output logic [2*HALF_W-1:0] wr_ptr_o,
    output logic [2*HALF_W-1:0] rd_ptr_o,
    output logic [2*HALF_W-1:0] dist_o,
    output logic [2*HALF_W-1:0] brk_o,
    output logic [2*HALF_W-1:0] hi_wm_o,
    output logic [2*HALF_W-1:0] lo_wm_o
);
    localparam int PTR_W = 2 * HALF_W;
    localparam logic [PTR_W-1:0] STEP = PTR_W'(BURST_BYTES);

    logic [PTR_W-1:0]     q      [RING_REGS];
    logic [PTR_W-1:0]     hw_val [RING_REGS];
    logic [RING_REGS-1:0] hw_load;
    logic [PTR_W-1:0]     wr_next;
    logic [PTR_W-1:0]     rd_next;
    logic                 prod_ok;
    logic                 cons_ok;

    // Acceptance of producer bursts and consumer steps.
    always_comb begin
        prod_ok     = burst_valid && link_en;
        cons_ok     = consume_req && read_en && (q[RG_DIST] != '0);
        consume_ack = cons_ok;
    end

    cmd_ring_step #(.PTR_W(PTR_W), .BURST_BYTES(BURST_BYTES)) u_wr_step (
        .cur  (q[RG_WPTR]),
        .start(q[RG_START]),
        .limit(q[RG_LIMIT]),
        .nxt  (wr_next)
    );

    cmd_ring_step #(.PTR_W(PTR_W), .BURST_BYTES(BURST_BYTES)) u_rd_step (
        .cur  (q[RG_RPTR]),
        .start(q[RG_START]),
        .limit(q[RG_LIMIT]),
        .nxt  (rd_next)
    );

    // Hardware load requests for the pointers and the distance.
    always_comb begin
        for (int i = 0; i < RING_REGS; i++) begin
            hw_val[i] = q[i];
        end
        hw_load          = '0;
        hw_load[RG_WPTR] = prod_ok;
        hw_val[RG_WPTR]  = wr_next;
        hw_load[RG_RPTR] = cons_ok;
        hw_val[RG_RPTR]  = rd_next;
        hw_load[RG_DIST] = prod_ok ^ cons_ok;
        hw_val[RG_DIST]  = prod_ok ? q[RG_DIST] + STEP : q[RG_DIST] - STEP;
    end

    cmd_ring_regs #(
        .HALF_W     (HALF_W),
        .ADDR_W     (ADDR_W),
        .BURST_BYTES(BURST_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid),
        .hw_load   (hw_load),
        .hw_val    (hw_val),
        .q         (q)
    );

    // Export of the register bank to the status and interrupt unit.
    always_comb begin
        base_o   = q[RG_START];
        end_o    = q[RG_LIMIT];
        wr_ptr_o = q[RG_WPTR];
        rd_ptr_o = q[RG_RPTR];
        dist_o   = q[RG_DIST];
        brk_o    = q[RG_BRK];
        hi_wm_o  = q[RG_HIWM];
        lo_wm_o  = q[RG_LOWM];
    end
endmodule

// File: rtl/cmd_ring_ptr_mgr_chk.sv
// Module: checker for cmd_ring_ptr_mgr. It sees only the top-level ports and
// is attached through bind.
module cmd_ring_ptr_mgr_chk #(
    parameter int HALF_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int BURST_BYTES = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_en,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_rvalid,
    input logic                link_en,
    input logic                read_en,
    input logic                burst_valid,
    input logic                consume_req,
    input logic                consume_ack,
    input logic [2*HALF_W-1:0] base_o,
    input logic [2*HALF_W-1:0] end_o,
    input logic [2*HALF_W-1:0] wr_ptr_o,
    input logic [2*HALF_W-1:0] rd_ptr_o,
    input logic [2*HALF_W-1:0] dist_o
);
    localparam int PTR_W = 2 * HALF_W;
    localparam logic [PTR_W-1:0] STEP = PTR_W'(BURST_BYTES);
    localparam logic [PTR_W-1:0] OFFS = PTR_W'(BURST_BYTES - 1);

    logic wr_any;
    logic prod;
    always_comb begin
        wr_any = reg_en && reg_we;
        prod   = burst_valid && link_en;
    end

    assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(1)) |=> base_o[HALF_W-1:0] == $past(base_o[HALF_W-1:0]));

    assert_limit_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(2)) |=> (end_o & OFFS) == '0);

    assert_unlinked_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !link_en && !wr_any && !consume_req) |=> ($stable(wr_ptr_o) && $stable(dist_o)));

    assert_wptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prod && !wr_any) |=> wr_ptr_o == ($past(wr_ptr_o >= end_o) ? $past(base_o) : $past(wr_ptr_o) + STEP));

    assert_dist_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod && !consume_ack && !wr_any) |=> dist_o == $past(dist_o) + STEP);

    assert_no_ack_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_o == '0 || !read_en || !consume_req) |-> !consume_ack);

    assert_dist_shrink_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_ack && !prod && !wr_any) |=> (dist_o == $past(dist_o) - STEP && $stable(wr_ptr_o)));

    assert_dist_balanced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_ack && prod && !wr_any) |=> $stable(dist_o));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr[ADDR_W-1] && !burst_valid && !consume_req)
            |=> ($stable(base_o) && $stable(end_o) && $stable(wr_ptr_o) && $stable(rd_ptr_o) && $stable(dist_o)));

    assert_read_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we) |=> reg_rvalid);

    assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> !reg_rvalid);
endmodule

bind cmd_ring_ptr_mgr cmd_ring_ptr_mgr_chk #(
    .HALF_W     (HALF_W),
    .ADDR_W     (ADDR_W),
    .BURST_BYTES(BURST_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rvalid (reg_rvalid),
    .link_en    (link_en),
    .read_en    (read_en),
    .burst_valid(burst_valid),
    .consume_req(consume_req),
    .consume_ack(consume_ack),
    .base_o     (base_o),
    .end_o      (end_o),
    .wr_ptr_o   (wr_ptr_o),
    .rd_ptr_o   (rd_ptr_o),
    .dist_o     (dist_o)
);

// File: tb/test_cmd_ring_ptr_mgr.sv
// Testbench: scoreboard for register reads plus direct checks on the exports.
module test_cmd_ring_ptr_mgr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic        link_en = 1'b0;
    logic        read_en = 1'b0;
    logic        burst_valid = 1'b0;
    logic        consume_req = 1'b0;
    logic        consume_ack;
    logic [31:0] base_o, end_o, wr_ptr_o, rd_ptr_o, dist_o, brk_o, hi_wm_o, lo_wm_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_ptr_mgr i_cmd_ring_ptr_mgr (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .link_en(link_en), .read_en(read_en),
        .burst_valid(burst_valid), .consume_req(consume_req), .consume_ack(consume_ack),
        .base_o(base_o), .end_o(end_o), .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o),
        .dist_o(dist_o), .brk_o(brk_o), .hi_wm_o(hi_wm_o), .lo_wm_o(lo_wm_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected read value for every valid read beat.
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: actual=%04h expected=<no read pending>", reg_rdata);
            end else begin
                chk(tag_q.pop_front(), {16'h0, reg_rdata}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic burst();
        @(negedge clk);
        burst_valid = 1'b1;
        @(negedge clk);
        burst_valid = 1'b0;
    endtask

    task automatic consume(input logic exp_ack, input string tag);
        @(negedge clk);
        consume_req = 1'b1;
        #1 chk(tag, {31'h0, consume_ack}, {31'h0, exp_ack});
        @(negedge clk);
        consume_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 wptr", wr_ptr_o, 0);
        chk("R1 dist", dist_o, 0);
        chk("R1 brk", brk_o, 0);
        chk("R1 ack", {31'h0, consume_ack}, 0);
        rd(5'd1, 16'h0000, "R1 start hi");

        // R3: aligned low halves; R2: halves
        wr(5'd0, 16'h1234); wr(5'd1, 16'h0001);
        chk("R3 start", base_o, 32'h0001_1220);
        wr(5'd2, 16'h1280); wr(5'd3, 16'h0001);
        chk("R2 limit", end_o, 32'h0001_1280);
        wr(5'd4, 16'h1260); wr(5'd5, 16'h0001);
        chk("R2 wptr", wr_ptr_o, 32'h0001_1260);
        // R4: threshold low half unmasked
        wr(5'd12, 16'hABCD);
        chk("R4 upper", hi_wm_o, 32'h0000_ABCD);
        wr(5'd15, 16'h7777); wr(5'd14, 16'h001F);
        chk("R4 lower", lo_wm_o, 32'h7777_001F);
        // R2: breakpoint halves kept apart
        wr(5'd10, 16'hFFFF); wr(5'd11, 16'h5555);
        rd(5'd10, 16'hFFE0, "R3 brk lo");
        rd(5'd11, 16'h5555, "R2 brk hi");
        wr(5'd10, 16'h0040);
        chk("R2 brk keep hi", brk_o, 32'h5555_0040);

        // R5: unlinked burst ignored
        burst();
        chk("R5 wptr", wr_ptr_o, 32'h0001_1260);
        chk("R5 dist", dist_o, 0);

        // R6/R7: linked bursts with wrap
        link_en = 1'b1;
        burst();
        chk("R6 advance", wr_ptr_o, 32'h0001_1280);
        chk("R7 dist", dist_o, 32'h20);
        burst();
        chk("R6 wrap", wr_ptr_o, 32'h0001_1220);
        chk("R7 dist", dist_o, 32'h40);
        burst();
        chk("R6 advance", wr_ptr_o, 32'h0001_1240);
        chk("R7 dist", dist_o, 32'h60);

        // R8/R9: consumer side
        wr(5'd6, 16'h1260); wr(5'd7, 16'h0001);
        consume(1'b0, "R8 read disabled ack");
        chk("R8 rptr kept", rd_ptr_o, 32'h0001_1260);
        chk("R8 dist kept", dist_o, 32'h60);
        read_en = 1'b1;
        consume(1'b1, "R8 ack");
        chk("R9 rptr", rd_ptr_o, 32'h0001_1280);
        chk("R9 dist", dist_o, 32'h40);
        consume(1'b1, "R8 ack");
        chk("R9 rptr wrap", rd_ptr_o, 32'h0001_1220);
        chk("R9 dist", dist_o, 32'h20);
        @(negedge clk);
        burst_valid = 1'b1; consume_req = 1'b1;
        @(negedge clk);
        burst_valid = 1'b0; consume_req = 1'b0;
        chk("R9 both dist", dist_o, 32'h20);
        chk("R9 both wptr", wr_ptr_o, 32'h0001_1260);
        chk("R9 both rptr", rd_ptr_o, 32'h0001_1240);
        consume(1'b1, "R8 ack");
        chk("R9 drained", dist_o, 0);
        consume(1'b0, "R8 empty ack");
        chk("R8 empty rptr", rd_ptr_o, 32'h0001_1260);

        // R11: register write beats burst on the write pointer
        @(negedge clk);
        burst_valid = 1'b1; reg_en = 1'b1; reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 16'h0105;
        @(negedge clk);
        burst_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        chk("R11 wptr", wr_ptr_o, 32'h0001_0100);
        chk("R11 dist", dist_o, 32'h20);
        wr(5'd8, 16'h0047);
        chk("R3 dist", dist_o, 32'h40);
        rd(5'd8, 16'h0040, "R12 dist lo");

        // R10: unmapped space
        wr(5'd16, 16'hFFFF); wr(5'd31, 16'hFFFF);
        chk("R10 start", base_o, 32'h0001_1220);
        chk("R10 limit", end_o, 32'h0001_1280);
        chk("R10 wptr", wr_ptr_o, 32'h0001_0100);
        chk("R10 rptr", rd_ptr_o, 32'h0001_1260);
        chk("R10 dist", dist_o, 32'h40);
        rd(5'd16, 16'h0000, "R10 read");
        rd(5'd31, 16'h0000, "R10 read");
        rd(5'd3, 16'h0001, "R12 limit hi");
        rd(5'd2, 16'h1280, "R12 limit lo");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12: actual=%0d expected=0 reads outstanding", exp_q.size());
        end
        finish_run();
    end
endmodule